// File: doc/BRIEF.md
# Fail-First Element Loop Sequencer

This block is the loop controller behind a scalar-prefixed vector operation. A start pulse captures a vector length, a fail-first enable and a base condition field. The sequencer then issues element operations one by one, from index 0 upward, handing the execution unit the element index and the operand register offset. For each element, the execution unit returns a test outcome and a 4-bit condition co-result.

With fail-first enabled, the first element whose test is true ends the loop. The vector length is then rewritten to that element's index, and neither that element nor any later one writes its co-result. The block does not cover the element datapath.

Each accepted co-result is steered into its own condition field. The field number is the base plus the element index, taken modulo the field count. The condition space holds 128 fields of 4 bits, packed eight to a 32-bit register across sixteen registers. The block reports the target register, the field within it, the field's starting bit offset, and a 32-bit write mask with the data already aligned.

Top module: `ff_loop_seq`

## Requirements
- R1: After a start pulse with nonzero VL, `elem_valid_o` pulses for one cycle for each element in ascending order from 0. Element i+1 is issued only after the result for element i has been accepted.
- R2: While `elem_valid_o` is high, `reg_off_o` equals the element index `elem_idx_o`.
- R3: With fail-first enabled, a true test on element i causes three things on the next cycle: `vl_o` becomes i, `done_o` pulses and `busy_o` falls. No further element is issued.
- R4: A condition write (`cr_we_o` high in the cycle `test_valid_i` is high) happens for every accepted result, except when fail-first is enabled and the test is true. No field beyond the truncated VL is written.
- R5: If no element fires, `vl_o` keeps the captured VL and `done_o` pulses on the cycle after the result for element VL-1.
- R6: A start with VL of zero pulses `done_o` on the next cycle, issues no element and leaves `vl_o` at 0.
- R7: With fail-first disabled, `test_i` is ignored: all VL elements are issued and all write their fields.
- R8: Element i targets field f = (base + i) mod 128. This gives `cr_reg_o` = f[6:3], `cr_sel_o` = f[2:0], `cr_bit_o` = 4·f[2:0] (a 5-bit bit offset) and `cr_field_o` = f.
- R9: Field k of a register occupies bits 4k+3..4k. `cr_wmask_o` has exactly those four bits set during a write, and `cr_wdata_o` carries `cr_res_i` in them.
- R10: A start pulse while `busy_o` is high is ignored and does not change the running loop's VL, length or fields.
- R11: After reset the block is idle: `busy_o`, `elem_valid_o`, `done_o` and `cr_we_o` are low and `vl_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| vl_i | input | 8 | Vector length, 0 to 128 |
| ff_en_i | input | 1 | Data-dependent fail-first enable |
| cr_base_i | input | 7 | Condition field used by element 0 |
| elem_valid_o | output | 1 | Element issue strobe |
| elem_idx_o | output | 7 | Index of the issued element |
| reg_off_o | output | 7 | Operand register offset of the issued element |
| test_valid_i | input | 1 | Result of the outstanding element is present |
| test_i | input | 1 | Test outcome for that element |
| cr_res_i | input | 4 | Condition co-result for that element |
| cr_we_o | output | 1 | Condition field write strobe |
| cr_reg_o | output | 4 | Target condition register |
| cr_sel_o | output | 3 | Field within the register |
| cr_bit_o | output | 5 | Bit offset of the field's lowest bit |
| cr_field_o | output | 7 | Absolute condition field number |
| cr_wmask_o | output | 32 | Register-wide write mask |
| cr_wdata_o | output | 32 | Co-result aligned to its field |
| vl_o | output | 8 | Captured VL, rewritten on fail-first |
| done_o | output | 1 | One-cycle end-of-loop pulse |
| busy_o | output | 1 | Loop in progress |

## Verification
Loops with all tests false, and with fail-first disabled but every test true, show that the test is ignored when fail-first is off. Fail-first runs where the test fires on element 0, on a middle element and on element 127 of a full-length loop separate truncation at either end from the general case. A fail-first run where nothing fires shows that VL is kept. A base near the top of the field space forces the field number to wrap and the register index to roll over. Separate runs cover a zero VL and a start pulse injected mid-loop, with result latencies varied per element.

// File: rtl/ffseq_pkg.sv
package ffseq_pkg;
  localparam int unsigned N_FIELDS       = 128;
  localparam int unsigned FIELD_W        = 4;
  localparam int unsigned FIELDS_PER_REG = 8;
  localparam int unsigned REG_W          = FIELD_W * FIELDS_PER_REG;
  localparam int unsigned N_REGS         = N_FIELDS / FIELDS_PER_REG;
  localparam int unsigned FLD_W          = $clog2(N_FIELDS);
  localparam int unsigned SEL_W          = $clog2(FIELDS_PER_REG);
  localparam int unsigned REG_IDX_W      = $clog2(N_REGS);
  localparam int unsigned BIT_W          = $clog2(REG_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [REG_IDX_W-1:0] reg_idx;
    logic [SEL_W-1:0]     sel;
  } cr_addr_t;
endpackage

// File: rtl/ffseq_ctrl.sv
module ffseq_ctrl
  import ffseq_pkg::*;
#(
  parameter int unsigned MAX_VL = 128,
  localparam int unsigned IDX_W = $clog2(MAX_VL),
  localparam int unsigned VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic             ff_en_i,
  input  logic             test_valid_i,
  input  logic             test_i,
  output logic             elem_valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [VL_W-1:0]  vl_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             wr_ok_o
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [VL_W-1:0]  vl_q;
  logic             ff_q;
  logic             done_q;
  logic             accept, fire, last;

  assign accept  = (state_q == ST_WAIT) && test_valid_i;
  assign fire    = ff_q && test_i;
  assign last    = (VL_W'(idx_q) + 1'b1) == vl_q;
  assign wr_ok_o = accept && !fire;

  assign elem_valid_o = (state_q == ST_ISSUE);
  assign idx_o        = idx_q;
  assign vl_o         = vl_q;
  assign done_o       = done_q;
  assign busy_o       = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vl_q    <= '0;
      ff_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            vl_q  <= vl_i;
            ff_q  <= ff_en_i;
            idx_q <= '0;
            if (vl_i == '0) done_q  <= 1'b1;
            else            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (accept) begin
            if (fire) begin
              // truncate VL to the failing element
              vl_q    <= VL_W'(idx_q);
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (last) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  next_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !fire && !last) |=> (elem_valid_o && idx_o == $past(idx_o) + 1'b1));
  // R3
  ff_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && fire) |=> (done_o && !busy_o && vl_o == VL_W'($past(idx_o))));
  // R5
  vl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !fire && last) |=> (done_o && !busy_o && vl_o == $past(vl_o)));
  // R6
  vl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && vl_i == '0) |=> (done_o && !busy_o && !elem_valid_o));
  // R10
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !accept) |=> $stable(vl_o));
endmodule

// File: rtl/ffseq_cr_map.sv
module ffseq_cr_map
  import ffseq_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic [FLD_W-1:0]   base_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               we_i,
  input  logic [FIELD_W-1:0] res_i,
  output logic [FLD_W-1:0]   field_o,
  output cr_addr_t           addr_o,
  output logic [BIT_W-1:0]   bit_o,
  output logic [REG_W-1:0]   wmask_o,
  output logic [REG_W-1:0]   wdata_o
);
  logic [FLD_W-1:0] field;

  // modulo wrap over the field space
  assign field   = base_i + FLD_W'(idx_i);
  assign field_o = field;
  assign addr_o  = cr_addr_t'(field);
  assign bit_o   = BIT_W'(addr_o.sel) * BIT_W'(FIELD_W);

  for (genvar g = 0; g < FIELDS_PER_REG; g++) begin : g_lane
    logic hit;
    assign hit = (addr_o.sel == SEL_W'(g));
    assign wmask_o[g*FIELD_W +: FIELD_W] = {FIELD_W{we_i && hit}};
    assign wdata_o[g*FIELD_W +: FIELD_W] = hit ? res_i : '0;
  end
endmodule

// File: rtl/ff_loop_seq.sv
module ff_loop_seq
  import ffseq_pkg::*;
#(
  parameter int unsigned MAX_VL = 128,
  localparam int unsigned IDX_W = $clog2(MAX_VL),
  localparam int unsigned VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [VL_W-1:0]      vl_i,
  input  logic                 ff_en_i,
  input  logic [FLD_W-1:0]     cr_base_i,
  output logic                 elem_valid_o,
  output logic [IDX_W-1:0]     elem_idx_o,
  output logic [IDX_W-1:0]     reg_off_o,
  input  logic                 test_valid_i,
  input  logic                 test_i,
  input  logic [FIELD_W-1:0]   cr_res_i,
  output logic                 cr_we_o,
  output logic [REG_IDX_W-1:0] cr_reg_o,
  output logic [SEL_W-1:0]     cr_sel_o,
  output logic [BIT_W-1:0]     cr_bit_o,
  output logic [FLD_W-1:0]     cr_field_o,
  output logic [REG_W-1:0]     cr_wmask_o,
  output logic [REG_W-1:0]     cr_wdata_o,
  output logic [VL_W-1:0]      vl_o,
  output logic                 done_o,
  output logic                 busy_o
);
  logic [IDX_W-1:0] idx;
  logic [FLD_W-1:0] base_q;
  logic             wr_ok;
  cr_addr_t         addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                base_q <= '0;
    else if (start_i && !busy_o) base_q <= cr_base_i;
  end

  ffseq_ctrl #(.MAX_VL(MAX_VL)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .vl_i, .ff_en_i, .test_valid_i, .test_i,
    .elem_valid_o, .idx_o(idx), .vl_o, .done_o, .busy_o, .wr_ok_o(wr_ok)
  );

  ffseq_cr_map #(.IDX_W(IDX_W)) i_cr_map (
    .base_i(base_q), .idx_i(idx), .we_i(wr_ok), .res_i(cr_res_i),
    .field_o(cr_field_o), .addr_o(addr), .bit_o(cr_bit_o),
    .wmask_o(cr_wmask_o), .wdata_o(cr_wdata_o)
  );

  assign elem_idx_o = idx;
  assign reg_off_o  = idx;
  assign cr_we_o    = wr_ok;
  assign cr_reg_o   = addr.reg_idx;
  assign cr_sel_o   = addr.sel;

  // R9
  mask_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> ($countones(cr_wmask_o) == FIELD_W));
  // R4
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cr_we_o);
  // R1
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!elem_valid_o && !busy_o));
endmodule

// File: tb/test_ff_loop_seq.sv
`timescale 1ns/1ps
module test_ff_loop_seq;
  localparam int MAX_VL = 128;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  vl_i = '0;
  logic        ff_en_i = 1'b0;
  logic [6:0]  cr_base_i = '0;
  logic        elem_valid_o;
  logic [6:0]  elem_idx_o, reg_off_o;
  logic        test_valid_i = 1'b0;
  logic        test_i = 1'b0;
  logic [3:0]  cr_res_i = '0;
  logic        cr_we_o;
  logic [3:0]  cr_reg_o;
  logic [2:0]  cr_sel_o;
  logic [4:0]  cr_bit_o;
  logic [6:0]  cr_field_o;
  logic [31:0] cr_wmask_o, cr_wdata_o;
  logic [7:0]  vl_o;
  logic        done_o, busy_o;

  int total = 0;
  int bad   = 0;
  int issued = 0;

  typedef struct packed {
    logic [6:0]  field;
    logic [31:0] mask;
    logic [31:0] data;
  } exp_wr_t;
  exp_wr_t exp_q[$];

  always #2 clk_i = ~clk_i;

  ff_loop_seq #(.MAX_VL(MAX_VL)) i_ff_loop_seq (
    .clk_i, .rst_ni, .start_i, .vl_i, .ff_en_i, .cr_base_i,
    .elem_valid_o, .elem_idx_o, .reg_off_o,
    .test_valid_i, .test_i, .cr_res_i,
    .cr_we_o, .cr_reg_o, .cr_sel_o, .cr_bit_o, .cr_field_o,
    .cr_wmask_o, .cr_wdata_o, .vl_o, .done_o, .busy_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: counts issues and pops expected field writes
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (elem_valid_o) issued++;
      if (cr_we_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected write", {25'd0, cr_field_o}, 32'd0);
        end else begin
          exp_wr_t e;
          e = exp_q.pop_front();
          chk(cr_field_o == e.field, "R8 field", {25'd0, cr_field_o}, {25'd0, e.field});
          chk(cr_reg_o == e.field[6:3] && cr_sel_o == e.field[2:0]
              && cr_bit_o == {e.field[2:0], 2'b00}, "R8 reg/sel/bit",
              {20'd0, cr_reg_o, cr_sel_o, cr_bit_o}, {20'd0, e.field[6:3], e.field[2:0], e.field[2:0], 2'b00});
          chk(cr_wmask_o == e.mask, "R9 mask", cr_wmask_o, e.mask);
          chk(cr_wdata_o == e.data, "R9 data", cr_wdata_o, e.data);
        end
      end
    end
  end

  // driver: run one loop; fail_at < 0 means no element fires
  task automatic run_loop(input int vl, input bit ff, input int base, input int fail_at,
                          input bit all_true, input bit poke);
    int n_issue, exp_vl;
    bit fired;
    fired   = ff && fail_at >= 0 && fail_at < vl;
    n_issue = fired ? fail_at + 1 : vl;
    exp_vl  = fired ? fail_at : vl;
    issued  = 0;
    @(posedge clk_i) #1;
    start_i = 1'b1; vl_i = 8'(vl); ff_en_i = ff; cr_base_i = 7'(base);
    @(posedge clk_i) #1;
    start_i = 1'b0;
    if (vl == 0) begin
      chk(done_o && !busy_o, "R6 done on zero VL", {31'd0, done_o}, 32'd1);
    end
    for (int i = 0; i < n_issue; i++) begin
      bit t;
      logic [6:0] f;
      logic [3:0] r;
      chk(elem_valid_o && elem_idx_o == 7'(i), "R1 issue order", {25'd0, elem_idx_o}, i);
      chk(reg_off_o == 7'(i), "R2 register offset", {25'd0, reg_off_o}, i);
      @(posedge clk_i) #1;
      if (poke && i == 0) begin
        start_i = 1'b1; vl_i = 8'd2; ff_en_i = ~ff; cr_base_i = 7'd99;
        @(posedge clk_i) #1;
        start_i = 1'b0;
      end
      repeat (i % 3) @(posedge clk_i) #1;
      t = (i == fail_at) || all_true;
      r = 4'(i * 5 + 3);
      f = 7'(base + i);
      test_valid_i = 1'b1; test_i = t; cr_res_i = r;
      if (!(ff && t))
        exp_q.push_back('{field: f, mask: 32'hF << (4 * f[2:0]), data: {28'd0, r} << (4 * f[2:0])});
      @(posedge clk_i) #1;
      test_valid_i = 1'b0; test_i = 1'b0;
    end
    chk(done_o && !busy_o, "R5 done pulse at loop end", {31'd0, done_o}, 32'd1);
    chk(vl_o == 8'(exp_vl), fired ? "R3 truncated VL" : "R5 VL kept", {24'd0, vl_o}, exp_vl);
    @(negedge clk_i);
    chk(issued == n_issue, fired ? "R3 no issue after fail" : "R7 all elements issued", issued, n_issue);
    chk(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
    exp_q.delete();
    @(posedge clk_i) #1;
    chk(!done_o && !busy_o && !elem_valid_o, "R1 quiet after done", {31'd0, done_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!busy_o && !elem_valid_o && !done_o && !cr_we_o && vl_o == 8'd0,
        "R11 reset state", {24'd0, vl_o}, 32'd0);
    @(posedge clk_i) #1;
    rst_ni = 1'b1;

    run_loop(5,   1'b0, 0,   -1,  1'b0, 1'b0); // R1 R2 R5 R8 R9
    run_loop(6,   1'b1, 10,  3,   1'b0, 1'b0); // R3 R4 mid fail
    run_loop(4,   1'b0, 17,  -1,  1'b1, 1'b0); // R7 test ignored
    run_loop(0,   1'b1, 5,   -1,  1'b0, 1'b0); // R6
    run_loop(3,   1'b1, 40,  0,   1'b0, 1'b0); // R3 R4 fail on first
    run_loop(8,   1'b0, 124, -1,  1'b0, 1'b0); // R8 wrap
    run_loop(3,   1'b1, 64,  -1,  1'b0, 1'b0); // R5 ff without fire
    run_loop(3,   1'b0, 30,  -1,  1'b0, 1'b1); // R10 start while busy
    run_loop(128, 1'b1, 0,   127, 1'b0, 1'b0); // R3 fail on last of full VL

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule